// File: doc/BRIEF.md
# Byte-Serial Acquisition Sample Buffer

This block is the sample store between an analog-to-digital converter and a host that has only an 8-bit data port. The converter side offers one 16-bit sample per cycle on a valid/data pair. Each accepted sample goes into a 2048-entry memory. The host takes a sample out with two byte reads from a single data address, low byte first.

Byte writes to that same data address load two 16-bit threshold words. The host sees one status byte that combines live level flags with three sticky events. The events clear when the host reads the status byte. A one-cycle clear strobe empties the buffer and sets both byte phases back to their first position. An interrupt request is raised when the interrupt enable is set and a threshold event is pending.

The near-full threshold is a count of free bytes, not a count of stored samples. The host picks how much headroom is left when the event fires. The near-empty word is accepted so that the four-byte write sequence stays in step, but it has no effect on any output.

Top module: `acq_byte_fifo`

## Requirements
- R1: The buffer holds up to 2048 samples. Status bit 2 (full) is 1 exactly when 2048 samples are stored. Status bit 0 (empty) is 1 exactly when none are stored.
- R2: A sample is read as two byte reads: the low byte on the first read and the high byte on the second. The second read removes the sample. `host_rbyte` shows the result from the second rising edge after the read strobe. Samples come out in arrival order.
- R3: Byte writes to the data address cycle through four positions. Positions 0 and 1 (the near-empty word) are discarded. Position 2 is the near-full low byte and position 3 is its high byte. The new value takes effect on the position-3 write, and the next write returns to position 0.
- R4: Status bit 1 (near full) is 1 while 2*(2048 - stored samples) is at or below the near-full value. Status bit 3 (threshold event) sets one cycle after bit 1 goes from 0 to 1. The near-full value resets to 0.
- R5: Status layout: bit7 idle, bit6 running, bit5 data lost, bit4 end of scan, bit3 threshold event, bit2 full, bit1 near full, bit0 empty. Running is `acq_run` registered and idle is its inverse. After reset the byte is 0x81 when `acq_run` is 0.
- R6: Bits 5, 4 and 3 are sticky. A `host_stat_rd` strobe clears them at the next edge, unless the same event sets again in that cycle.
- R7: A `fifo_clr` strobe empties the buffer at the next edge. It returns the read byte phase to low and the threshold write position to 0. It keeps the sticky events and the near-full value.
- R8: `irq` is 1 in the cycle after `irq_en` is 1 and a threshold event is pending.
- R9: A sample offered while the buffer is full is dropped. It sets the data-lost event and leaves the stored contents unchanged.
- R10: A byte read while the buffer is empty returns 0x00 and leaves the read byte phase where it was.
- R11: A one-cycle `scan_end` pulse sets the end-of-scan event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cv_valid | input | 1 | Converter sample valid |
| cv_sample | input | 16 | Converter sample |
| host_data_rd | input | 1 | Byte read strobe on the data address |
| host_data_wr | input | 1 | Byte write strobe on the data address |
| host_wbyte | input | 8 | Byte written by the host |
| host_rbyte | output | 8 | Byte returned by a data read |
| host_stat_rd | input | 1 | Status read strobe; clears sticky events |
| status | output | 8 | Status byte |
| fifo_clr | input | 1 | Buffer clear strobe |
| irq_en | input | 1 | FIFO interrupt enable |
| acq_run | input | 1 | Acquisition running indication |
| scan_end | input | 1 | End-of-scan pulse |
| irq | output | 1 | FIFO interrupt request |

## Verification
A pointer or count error shows up at once as an out-of-order or repeated byte on `host_rbyte`. It also shows as empty/full flags that disagree with the number of samples pushed minus the number of sample pairs read. A byte phase that slips swaps the two halves of every later sample, so the next read pair exposes it. A misaligned threshold write position or a wrong free-byte comparison moves the edge where near full asserts by at least one sample. The bench therefore checks the status byte on both sides of that edge. Sticky-event faults appear on the next status read: either as bits that fail to clear or as an `irq` that does not follow.

// File: rtl/acqf_pkg.sv
`timescale 1ns/1ps
package acqf_pkg;
  localparam int SAMPLE_W = 16;
  localparam int BYTE_W   = 8;

  // status byte positions (host software decodes these)
  localparam int ST_EMPTY = 0;
  localparam int ST_NFULL = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_THR   = 3;
  localparam int ST_EOS   = 4;
  localparam int ST_LOST  = 5;
  localparam int ST_RUN   = 6;
  localparam int ST_IDLE  = 7;

  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_LOW  = 2'd1,
    RK_HIGH = 2'd2
  } rd_kind_e;

  typedef struct packed {
    logic lost;
    logic eos;
    logic thr;
  } evt_t;
endpackage

// File: rtl/acqf_store.sv
`timescale 1ns/1ps
module acqf_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/acqf_thr_load.sv
`timescale 1ns/1ps
module acqf_thr_load #(
  parameter int          TW        = 16,
  parameter logic [15:0] NF_RESET  = 16'd0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [7:0]    wbyte,
  output logic [TW-1:0] nf_thr
);
  localparam int NPOS = 4;
  localparam int PW   = $clog2(NPOS);

  logic [PW-1:0] pos;
  logic [7:0]    lo_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      lo_stage <= '0;
      nf_thr   <= TW'(NF_RESET);
    end else if (clr) begin
      pos <= '0;
    end else if (wr) begin
      pos <= pos + 1'b1;
      if (pos == PW'(2)) lo_stage <= wbyte;
      if (pos == PW'(3)) nf_thr   <= TW'({wbyte, lo_stage});
    end
  end

  // R3: the near-full value only changes on a position-3 write
  p_thr_on_last_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(nf_thr) |-> ($past(wr) && !$past(clr) && $past(pos) == PW'(3)));

  // R7: clear returns write position to 0
  p_clr_pos_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> pos == '0);
endmodule

// File: rtl/acqf_events.sv
`timescale 1ns/1ps
module acqf_events
  import acqf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_lost,
  input  logic set_eos,
  input  logic level,
  input  logic rd_clr,
  input  logic irq_en,
  output evt_t evt,
  output logic irq
);
  logic lvl_d;
  logic set_thr;
  evt_t evt_n;

  assign set_thr = level & ~lvl_d;

  always_comb begin
    evt_n.lost = set_lost | (evt.lost & ~rd_clr);
    evt_n.eos  = set_eos  | (evt.eos  & ~rd_clr);
    evt_n.thr  = set_thr  | (evt.thr  & ~rd_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d <= 1'b0;
      evt   <= '0;
      irq   <= 1'b0;
    end else begin
      lvl_d <= level;
      evt   <= evt_n;
      irq   <= irq_en & evt_n.thr;
    end
  end

  // R6: a status read clears an event not re-set in that cycle
  p_lost_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !set_lost) |=> !evt.lost);
  p_eos_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !set_eos) |=> !evt.eos);
  // R4: a rising near-full level raises the threshold event
  p_thr_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |=> evt.thr);
  // R8: request only with a pending threshold event
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> evt.thr);
  // R11: end of scan is recorded
  p_eos_set_r11: assert property (@(posedge clk) disable iff (rst)
    set_eos |=> evt.eos);
endmodule

// File: rtl/acq_byte_fifo.sv
`timescale 1ns/1ps
module acq_byte_fifo
  import acqf_pkg::*;
#(
  parameter int          DEPTH    = 2048,
  parameter int          TW       = 16,
  parameter logic [15:0] NF_RESET = 16'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cv_valid,
  input  logic [15:0] cv_sample,
  input  logic        host_data_rd,
  input  logic        host_data_wr,
  input  logic [7:0]  host_wbyte,
  output logic [7:0]  host_rbyte,
  input  logic        host_stat_rd,
  output logic [7:0]  status,
  input  logic        fifo_clr,
  input  logic        irq_en,
  input  logic        acq_run,
  input  logic        scan_end,
  output logic        irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int FW   = CW + 1;
  localparam int CMPW = (FW > TW) ? FW : TW;

  logic [AW-1:0]       wp, rp;
  logic [CW-1:0]       count;
  logic                rd_phase;
  logic                full, empty;
  logic                push_ok, rd_ok, pop, mem_re;
  logic [SAMPLE_W-1:0] mem_q;
  logic [TW-1:0]       nf_thr;
  logic [FW-1:0]       free_b;
  logic [CMPW-1:0]     free_x, thr_x;
  logic                level;
  logic                run_q;
  logic                s1_v;
  rd_kind_e            s1_kind;
  logic [BYTE_W-1:0]   hi_hold;
  evt_t                evt;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = cv_valid & ~full & ~fifo_clr;
  assign rd_ok   = host_data_rd & ~fifo_clr & ~empty;
  assign pop     = rd_ok & rd_phase;
  assign mem_re  = rd_ok & ~rd_phase;

  // free space in bytes, compared against the near-full setting
  assign free_b = (FW'(DEPTH) - FW'(count)) << 1;
  assign free_x = CMPW'(free_b);
  assign thr_x  = CMPW'(nf_thr);
  assign level  = (free_x <= thr_x);

  acqf_store #(.DW(SAMPLE_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wp),
    .wdata (cv_sample),
    .re    (mem_re),
    .raddr (rp),
    .rdata (mem_q)
  );

  acqf_thr_load #(.TW(TW), .NF_RESET(NF_RESET)) u_thr (
    .clk    (clk),
    .rst    (rst),
    .clr    (fifo_clr),
    .wr     (host_data_wr),
    .wbyte  (host_wbyte),
    .nf_thr (nf_thr)
  );

  acqf_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .set_lost (cv_valid & full & ~fifo_clr),
    .set_eos  (scan_end),
    .level    (level),
    .rd_clr   (host_stat_rd),
    .irq_en   (irq_en),
    .evt      (evt),
    .irq      (irq)
  );

  // pointers, occupancy and read byte phase
  always_ff @(posedge clk) begin
    if (rst || fifo_clr) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      rd_phase <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (rd_ok) rd_phase <= ~rd_phase;
    end
  end

  // two-stage host read path: memory read, then byte select
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v       <= 1'b0;
      s1_kind    <= RK_ZERO;
      hi_hold    <= '0;
      host_rbyte <= '0;
      run_q      <= 1'b0;
    end else begin
      run_q   <= acq_run;
      s1_v    <= host_data_rd;
      s1_kind <= !rd_ok ? RK_ZERO : (rd_phase ? RK_HIGH : RK_LOW);
      if (s1_v) begin
        case (s1_kind)
          RK_LOW: begin
            host_rbyte <= mem_q[BYTE_W-1:0];
            hi_hold    <= mem_q[SAMPLE_W-1:BYTE_W];
          end
          RK_HIGH: host_rbyte <= hi_hold;
          default: host_rbyte <= '0;
        endcase
      end
    end
  end

  always_comb begin
    status           = '0;
    status[ST_IDLE]  = ~run_q;
    status[ST_RUN]   = run_q;
    status[ST_LOST]  = evt.lost;
    status[ST_EOS]   = evt.eos;
    status[ST_THR]   = evt.thr;
    status[ST_FULL]  = full;
    status[ST_NFULL] = level;
    status[ST_EMPTY] = empty;
  end

  // R1: occupancy never exceeds capacity
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R9: offer while full is dropped and flagged
  p_drop_full_r9: assert property (@(posedge clk) disable iff (rst)
    (cv_valid && full && !fifo_clr && !host_data_rd) |=> (full && evt.lost));
  // R7: clear empties and realigns the read phase
  p_clr_empty_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (empty && !rd_phase));
  // R10: empty read keeps phase and returns zero
  p_empty_phase_r10: assert property (@(posedge clk) disable iff (rst)
    (host_data_rd && empty) |=> !rd_phase);
  p_empty_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (host_data_rd && empty) |=> ##1 (host_rbyte == '0));
  // R2: a pop only happens on the high-byte read
  p_pop_high_r2: assert property (@(posedge clk) disable iff (rst)
    (host_data_rd && !empty && !fifo_clr && !cv_valid && rd_phase) |=>
      (count == $past(count) - 1'b1));
endmodule

// File: tb/tb_acq_byte_fifo.sv
`timescale 1ns/1ps
module tb_acq_byte_fifo;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst;
  logic        cv_valid, host_data_rd, host_data_wr, host_stat_rd;
  logic        fifo_clr, irq_en, acq_run, scan_end;
  logic [15:0] cv_sample;
  logic [7:0]  host_wbyte, host_rbyte, status;
  logic        irq;

  always #2.5 clk = ~clk;

  acq_byte_fifo dut (
    .clk(clk), .rst(rst), .cv_valid(cv_valid), .cv_sample(cv_sample),
    .host_data_rd(host_data_rd), .host_data_wr(host_data_wr),
    .host_wbyte(host_wbyte), .host_rbyte(host_rbyte),
    .host_stat_rd(host_stat_rd), .status(status), .fifo_clr(fifo_clr),
    .irq_en(irq_en), .acq_run(acq_run), .scan_end(scan_end), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] q[$];
  int   thr_m = 0;
  bit   lost_m, eos_m, tev_m, lvl_m, run_m, ph_m, en_m;
  int   wpos_m = 0;
  logic [7:0] lo_m;

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit lvl_f(int n, int thr);
    return (2 * (DEPTH - n)) <= thr;
  endfunction

  function automatic logic [7:0] exp_stat();
    int n = q.size();
    return {~run_m, run_m, lost_m, eos_m, tev_m, n == DEPTH, lvl_f(n, thr_m), n == 0};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic upd_lvl();
    bit nl = lvl_f(q.size(), thr_m);
    if (nl && !lvl_m) tev_m = 1;
    lvl_m = nl;
  endtask

  task automatic push(logic [15:0] d);
    cv_valid = 1; cv_sample = d; tick(); cv_valid = 0;
    if (q.size() < DEPTH) q.push_back(d); else lost_m = 1;
    tick(); upd_lvl();
  endtask

  task automatic read_byte(string req);
    logic [7:0] e;
    host_data_rd = 1; tick(); host_data_rd = 0; tick();
    if (q.size() == 0) e = 8'h00;
    else if (!ph_m) begin e = q[0][7:0]; ph_m = 1; end
    else begin e = q[0][15:8]; void'(q.pop_front()); ph_m = 0; end
    check8(req, host_rbyte, e);
    tick(); upd_lvl();
  endtask

  task automatic wr_byte(logic [7:0] b);
    host_data_wr = 1; host_wbyte = b; tick(); host_data_wr = 0;
    if (wpos_m == 2) lo_m = b;
    if (wpos_m == 3) thr_m = {b, lo_m};
    wpos_m = (wpos_m + 1) % 4;
    tick(); tick(); upd_lvl();
  endtask

  task automatic stat_read(string req);
    check8(req, status, exp_stat());
    host_stat_rd = 1; tick(); host_stat_rd = 0;
    lost_m = 0; eos_m = 0; tev_m = 0;
    tick();
  endtask

  task automatic do_clear();
    fifo_clr = 1; tick(); fifo_clr = 0;
    q.delete(); ph_m = 0; wpos_m = 0;
    tick(); upd_lvl();
  endtask

  task automatic check_irq(string req);
    check8(req, {7'd0, irq}, {7'd0, en_m & tev_m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; cv_valid = 0; cv_sample = 0; host_data_rd = 0; host_data_wr = 0;
    host_wbyte = 0; host_stat_rd = 0; fifo_clr = 0; irq_en = 0; acq_run = 0;
    scan_end = 0; en_m = 0; run_m = 0;
    repeat (3) tick();
    rst = 0; tick();

    // R5 reset state
    check8("R5 reset status", status, 8'h81);
    check8("R8 reset irq", {7'd0, irq}, 8'h00);
    check8("R2 reset rbyte", host_rbyte, 8'h00);

    // R10 empty read, then phase still low
    read_byte("R10 empty read");
    check8("R10 status after empty read", status, exp_stat());
    push(16'hA1B2);
    read_byte("R10 low after empty");
    read_byte("R2 high byte");

    // R11 and R5 running/idle
    acq_run = 1; tick(); tick(); run_m = 1;
    scan_end = 1; tick(); scan_end = 0; eos_m = 1; tick();
    stat_read("R11 eos and running");
    stat_read("R6 events cleared");

    // random mix of pushes, byte reads, status reads
    for (int i = 0; i < 700; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 5) push(16'($urandom()));
      else if (r < 8) read_byte("R2 random read");
      else if (r == 8) stat_read("R5 random status");
      else begin
        if ($urandom_range(0, 1) == 1) begin
          scan_end = 1; tick(); scan_end = 0; eos_m = 1; tick();
        end else begin
          acq_run = ~acq_run; tick(); tick(); run_m = acq_run;
        end
      end
    end
    stat_read("R6 status after random");

    // R3 threshold: 2 discarded bytes, then near-full = 8 free bytes
    do_clear();
    wr_byte(8'h55); wr_byte(8'h66); wr_byte(8'h08); wr_byte(8'h00);
    stat_read("R3 status after load");
    for (int i = 0; i < 2043; i++) push(16'($urandom()));
    stat_read("R4 below near full");
    push(16'h0F0F);
    check8("R4 near full level", status, exp_stat());
    check_irq("R8 irq disabled");
    irq_en = 1; tick(); en_m = 1; tick();
    check_irq("R8 irq raised");
    stat_read("R4 threshold event");
    check_irq("R8 irq cleared");
    irq_en = 0; en_m = 0;

    // R1 full, R9 drop
    for (int i = 0; i < 4; i++) push(16'($urandom()));
    check8("R1 full flag", status, exp_stat());
    push(16'hDEAD);
    stat_read("R9 lost set");
    for (int i = 0; i < 2 * DEPTH; i++) read_byte("R9 contents intact");
    stat_read("R1 empty after drain");

    // R7 clear mid-sample
    push(16'h1111); push(16'h2222);
    read_byte("R7 low before clear");
    do_clear();
    stat_read("R7 status after clear");
    push(16'h1234);
    read_byte("R7 low after clear");
    read_byte("R7 high after clear");

    // R7 write position back to 0
    wr_byte(8'h77);
    do_clear();
    wr_byte(8'h00); wr_byte(8'h00); wr_byte(8'h00); wr_byte(8'h10);
    stat_read("R7 write position realigned");

    // R3 wrap to position 0
    wr_byte(8'hAA); wr_byte(8'hBB); wr_byte(8'h00); wr_byte(8'h00);
    stat_read("R3 wrap reload");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule